// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home node for a range of memory blocks in a directory-based coherence system with a parameterised number of caching sites. For every block it keeps a directory entry made of a sharer presence vector, an owner identifier, a waiting-requester identifier and a protocol state. Cache sites send it shared and exclusive requests and the responses to its recalls. The block answers with grants, recalls and invalidations, and it reads and writes a backing memory through a simple port with a one-cycle read latency.

Coherence actions are sent only to the sites the entry names, never broadcast. While a block waits for invalidation acknowledgements or for the owner's data, its entry sits in a transient state. Requests that arrive for that block are set aside in a small holding queue and replayed in arrival order once the entry settles. Traffic for other blocks keeps flowing in the meantime.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset every block is uncached (shared state, empty presence vector), `out_valid` is low and `in_ready` is high.
- R2: Input codes on `in_type` are 0 shared request, 1 exclusive request, 2 write-back reply with data, 3 invalidation acknowledgement, 4 flush reply with data. Output codes on `out_type` are 0 shared grant, 1 exclusive grant, 2 write-back command, 3 invalidate command, 4 flush command. `out_src` always carries `HOME_ID`. A shared request to a block that no site holds modified is answered with a shared grant carrying the memory word, and the requester is added to the sharers. An output held while `out_ready` is low keeps its values.
- R3: An exclusive request to a clean block that has no sharer other than the requester is granted at once with an exclusive grant carrying the memory word, with no invalidate command. The requester becomes the only recorded owner.
- R4: An exclusive request to a clean block that has other sharers sends one invalidate command to each of them except the requester, lowest site number first. The exclusive grant, carrying the memory word, follows only after the last acknowledgement. The requester then becomes owner.
- R5: A shared request to a modified block sends a write-back command to the owner. The owner's write-back reply data is written to memory and forwarded in a shared grant to the requester. Both sites are then sharers.
- R6: An exclusive request to a modified block sends a flush command to the owner. The flush reply data is written to memory and forwarded in an exclusive grant to the requester, which becomes the new owner.
- R7: A request to a block in a transient state produces no output until the block settles. Held requests are then served before any newer input message.
- R8: While one block is transient, requests to other blocks are served normally.
- R9: A reply that does not match what the addressed entry waits for (wrong site or wrong state) is consumed with no output, no memory write and no change to the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming message valid |
| in_ready | output | 1 | Incoming message accepted this cycle |
| in_type | input | 3 | Incoming message code |
| in_src | input | SW | Sending site |
| in_addr | input | ADDR_W | Block address |
| in_data | input | DATA_W | Data of write-back or flush replies |
| out_valid | output | 1 | Outgoing message valid |
| out_ready | input | 1 | Network takes the outgoing message |
| out_type | output | 3 | Outgoing message code |
| out_src | output | SW | Home site identifier |
| out_dst | output | SW | Destination site |
| out_addr | output | ADDR_W | Block address |
| out_data | output | DATA_W | Data of grants |
| mem_rd_en | output | 1 | Backing memory read strobe |
| mem_wr_en | output | 1 | Backing memory write strobe |
| mem_addr | output | ADDR_W | Backing memory address |
| mem_wdata | output | DATA_W | Backing memory write data |
| mem_rdata | input | DATA_W | Read data, valid one cycle after the strobe |

## Verification
Two functions can compete for the same idle cycle: replaying a held request whose block has just settled, and taking a fresh message waiting at the input. The bench provokes this by closing an invalidation round with the last acknowledgement and, straight after it, offering a shared request for an unrelated block while an older request for the settled block is held. The scoreboard expects the exclusive grant first, then the recall caused by the replayed request, and only then the grant for the fresh request. Any other order, or any output for the held request before the acknowledgements, is reported.

// File: rtl/hdc_pkg.sv
package hdc_pkg;
  // incoming message codes
  localparam logic [2:0] MI_SH_REQ  = 3'd0;
  localparam logic [2:0] MI_EX_REQ  = 3'd1;
  localparam logic [2:0] MI_WB_RSP  = 3'd2;
  localparam logic [2:0] MI_INV_ACK = 3'd3;
  localparam logic [2:0] MI_FL_RSP  = 3'd4;
  // outgoing message codes
  localparam logic [2:0] MO_SH_GNT  = 3'd0;
  localparam logic [2:0] MO_EX_GNT  = 3'd1;
  localparam logic [2:0] MO_WB_CMD  = 3'd2;
  localparam logic [2:0] MO_INV_CMD = 3'd3;
  localparam logic [2:0] MO_FL_CMD  = 3'd4;

  typedef enum logic [1:0] {
    DS_SHARED    = 2'd0,  // sharers in vector, memory valid
    DS_OWNED     = 2'd1,  // one modified owner
    DS_WAIT_INV  = 2'd2,  // vector holds acks still pending
    DS_WAIT_DATA = 2'd3   // owner must return data
  } dstate_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_READ = 2'd1,
    SQ_SEND = 2'd2
  } seq_e;
endpackage

// File: rtl/hdc_dir.sv
module hdc_dir
  import hdc_pkg::*;
#(
  parameter int NSITE  = 4,
  parameter int ADDR_W = 4,
  parameter int SW     = 2,
  parameter int NBLK   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  // port A: decode
  input  logic [ADDR_W-1:0] ra_a,
  output dstate_e           ra_st,
  output logic [NSITE-1:0]  ra_vec,
  output logic [SW-1:0]     ra_own,
  output logic [SW-1:0]     ra_req,
  // port B: output-side view
  input  logic [ADDR_W-1:0] rb_a,
  output dstate_e           rb_st,
  output logic [NSITE-1:0]  rb_vec,
  output logic [SW-1:0]     rb_own,
  // write
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  dstate_e           w_st,
  input  logic [NSITE-1:0]  w_vec,
  input  logic [SW-1:0]     w_own,
  input  logic [SW-1:0]     w_req,
  output logic [NBLK-1:0]   busy
);
  dstate_e          st_q  [NBLK];
  logic [NSITE-1:0] vec_q [NBLK];
  logic [SW-1:0]    own_q [NBLK];
  logic [SW-1:0]    req_q [NBLK];

  always_ff @(posedge clk) begin
    for (int b = 0; b < NBLK; b++) begin
      if (!rst_n) begin
        st_q[b]  <= DS_SHARED;
        vec_q[b] <= '0;
        own_q[b] <= '0;
        req_q[b] <= '0;
      end else if (we && wa == ADDR_W'(b)) begin
        st_q[b]  <= w_st;
        vec_q[b] <= w_vec;
        own_q[b] <= w_own;
        req_q[b] <= w_req;
      end
    end
  end

  generate
    for (genvar g = 0; g < NBLK; g++) begin : g_busy
      assign busy[g] = (st_q[g] == DS_WAIT_INV) || (st_q[g] == DS_WAIT_DATA);
    end
  endgenerate

  assign ra_st  = st_q[ra_a];
  assign ra_vec = vec_q[ra_a];
  assign ra_own = own_q[ra_a];
  assign ra_req = req_q[ra_a];
  assign rb_st  = st_q[rb_a];
  assign rb_vec = vec_q[rb_a];
  assign rb_own = own_q[rb_a];

  // a settled entry in the owned state names exactly one site
  AST_OWNED_ONE_SITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_st == DS_OWNED) |-> $onehot0(ra_vec) && ra_vec != '0) else $error("owned entry vector"); // R3
endmodule

// File: rtl/hdc_park.sv
module hdc_park #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 4,
  parameter int SW     = 2,
  parameter int NBLK   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              push_ex,
  input  logic [SW-1:0]     push_src,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              pop,
  input  logic [NBLK-1:0]   busy,
  output logic              pick_valid,
  output logic              pick_ex,
  output logic [SW-1:0]     pick_src,
  output logic [ADDR_W-1:0] pick_addr,
  output logic              full
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] vld_q;
  logic             ex_q   [DEPTH];
  logic [SW-1:0]    src_q  [DEPTH];
  logic [ADDR_W-1:0] addr_q[DEPTH];
  logic [IW-1:0]    sel;
  logic [CW-1:0]    cnt;

  // oldest held entry whose block has settled (entries are kept packed low)
  always_comb begin
    pick_valid = 1'b0;
    sel        = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vld_q[i] && !busy[addr_q[i]]) begin
        pick_valid = 1'b1;
        sel        = IW'(i);
      end
    end
  end

  assign cnt       = CW'($countones(vld_q));
  assign full      = vld_q[DEPTH-1];
  assign pick_ex   = ex_q[sel];
  assign pick_src  = src_q[sel];
  assign pick_addr = addr_q[sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        ex_q[i]   <= 1'b0;
        src_q[i]  <= '0;
        addr_q[i] <= '0;
      end
    end else if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (i >= int'(sel)) begin
          vld_q[i]  <= vld_q[i+1];
          ex_q[i]   <= ex_q[i+1];
          src_q[i]  <= src_q[i+1];
          addr_q[i] <= addr_q[i+1];
        end
      end
      vld_q[DEPTH-1] <= 1'b0;
    end else if (push) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i == int'(cnt)) begin
          vld_q[i]  <= 1'b1;
          ex_q[i]   <= push_ex;
          src_q[i]  <= push_src;
          addr_q[i] <= push_addr;
        end
      end
    end
  end

  AST_PARK_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full) else $error("park overflow"); // R7
  AST_PARK_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop)) else $error("park push and pop together"); // R7
  AST_PARK_POP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> pick_valid) else $error("pop without pick"); // R7
endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl
  import hdc_pkg::*;
#(
  parameter int NSITE      = 4,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 16,
  parameter int PARK_DEPTH = 4,
  parameter int HOME_ID    = 0,
  localparam int SW        = (NSITE > 1) ? $clog2(NSITE) : 1,
  localparam int NBLK      = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_type,
  input  logic [SW-1:0]     in_src,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_type,
  output logic [SW-1:0]     out_src,
  output logic [SW-1:0]     out_dst,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  // ---------------- helper arithmetic ----------------
  function automatic logic [NSITE-1:0] site_bit(input logic [SW-1:0] id);
    return NSITE'(1) << id;
  endfunction

  function automatic logic [NSITE-1:0] lowest_one(input logic [NSITE-1:0] v);
    return v & (~v + NSITE'(1));
  endfunction

  function automatic logic [SW-1:0] oh_index(input logic [NSITE-1:0] oh);
    logic [SW-1:0] r;
    r = '0;
    for (int i = 0; i < NSITE; i++) if (oh[i]) r = SW'(i);
    return r;
  endfunction

  // ---------------- state ----------------
  seq_e              seq_q;
  logic              o_valid_q;
  logic [2:0]        o_type_q;
  logic [SW-1:0]     o_dst_q;
  logic [ADDR_W-1:0] o_addr_q;
  logic [DATA_W-1:0] o_data_q;
  logic [NSITE-1:0]  inv_left_q;

  // directory views
  dstate_e          ra_st, rb_st, w_st;
  logic [NSITE-1:0] ra_vec, rb_vec, w_vec;
  logic [SW-1:0]    ra_own, ra_req, rb_own, w_own, w_req;
  logic [NBLK-1:0]  blk_busy;
  logic             dir_we;

  // park views
  logic              pk_valid, pk_ex, pk_full;
  logic [SW-1:0]     pk_src;
  logic [ADDR_W-1:0] pk_addr;

  // named internal events
  logic              seq_idle;
  logic              use_park;
  logic              in_is_req;
  logic              in_defer;
  logic              in_accept;
  logic              park_push;
  logic              act;
  logic [2:0]        cur_type;
  logic [SW-1:0]     cur_src;
  logic [ADDR_W-1:0] cur_addr;

  assign seq_idle  = (seq_q == SQ_IDLE);
  assign use_park  = seq_idle && pk_valid;
  assign in_is_req = (in_type == MI_SH_REQ) || (in_type == MI_EX_REQ);
  assign in_defer  = in_is_req && blk_busy[in_addr];
  assign in_ready  = seq_idle && !pk_valid && !(in_defer && pk_full);
  assign in_accept = in_valid && in_ready;
  assign park_push = in_accept && in_defer;
  assign act       = use_park || (in_accept && !in_defer);

  assign cur_type = use_park ? (pk_ex ? MI_EX_REQ : MI_SH_REQ) : in_type;
  assign cur_src  = use_park ? pk_src : in_src;
  assign cur_addr = use_park ? pk_addr : in_addr;

  // ---------------- decode ----------------
  logic              d_we, d_rd, d_wr, d_ld;
  logic [2:0]        n_type;
  logic [SW-1:0]     n_dst;
  logic [NSITE-1:0]  n_inv;
  logic [NSITE-1:0]  req_bit, others, first_inv, acks_left;

  always_comb begin
    d_we   = 1'b0;
    d_rd   = 1'b0;
    d_wr   = 1'b0;
    d_ld   = 1'b0;
    w_st   = ra_st;
    w_vec  = ra_vec;
    w_own  = ra_own;
    w_req  = ra_req;
    n_type = MO_SH_GNT;
    n_dst  = cur_src;
    n_inv  = '0;
    req_bit   = site_bit(cur_src);
    others    = ra_vec & ~req_bit;
    first_inv = lowest_one(others);
    acks_left = ra_vec & ~req_bit;
    case (cur_type)
      MI_SH_REQ: begin
        if (ra_st == DS_OWNED) begin
          d_we = 1'b1; w_st = DS_WAIT_DATA; w_req = cur_src;
          d_ld = 1'b1; n_type = MO_WB_CMD; n_dst = ra_own;
        end else begin
          d_we = 1'b1; w_vec = ra_vec | req_bit;
          d_rd = 1'b1; n_type = MO_SH_GNT;
        end
      end
      MI_EX_REQ: begin
        if (ra_st == DS_OWNED) begin
          d_we = 1'b1; w_st = DS_WAIT_DATA; w_req = cur_src;
          d_ld = 1'b1; n_type = MO_FL_CMD; n_dst = ra_own;
        end else if (others == '0) begin
          d_we = 1'b1; w_st = DS_OWNED; w_own = cur_src; w_vec = req_bit;
          d_rd = 1'b1; n_type = MO_EX_GNT;
        end else begin
          d_we = 1'b1; w_st = DS_WAIT_INV; w_vec = others; w_req = cur_src;
          d_ld = 1'b1; n_type = MO_INV_CMD; n_dst = oh_index(first_inv);
          n_inv = others & ~first_inv;
        end
      end
      MI_WB_RSP: begin
        if (ra_st == DS_WAIT_DATA && ra_own == cur_src) begin
          d_we = 1'b1; w_st = DS_SHARED;
          w_vec = site_bit(ra_own) | site_bit(ra_req);
          d_wr = 1'b1; d_ld = 1'b1; n_type = MO_SH_GNT; n_dst = ra_req;
        end
      end
      MI_FL_RSP: begin
        if (ra_st == DS_WAIT_DATA && ra_own == cur_src) begin
          d_we = 1'b1; w_st = DS_OWNED; w_own = ra_req; w_vec = site_bit(ra_req);
          d_wr = 1'b1; d_ld = 1'b1; n_type = MO_EX_GNT; n_dst = ra_req;
        end
      end
      MI_INV_ACK: begin
        if (ra_st == DS_WAIT_INV && ra_vec[cur_src]) begin
          d_we = 1'b1;
          if (acks_left == '0) begin
            w_st = DS_OWNED; w_own = ra_req; w_vec = site_bit(ra_req);
            d_rd = 1'b1; n_type = MO_EX_GNT; n_dst = ra_req;
          end else begin
            w_vec = acks_left;
          end
        end
      end
      default: ;
    endcase
  end

  assign dir_we    = act && d_we;
  assign mem_rd_en = act && d_rd;
  assign mem_wr_en = act && d_wr;
  assign mem_addr  = cur_addr;
  assign mem_wdata = in_data;

  // ---------------- sequencer ----------------
  logic [NSITE-1:0] next_inv;
  assign next_inv = lowest_one(inv_left_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q      <= SQ_IDLE;
      o_valid_q  <= 1'b0;
      o_type_q   <= '0;
      o_dst_q    <= '0;
      o_addr_q   <= '0;
      o_data_q   <= '0;
      inv_left_q <= '0;
    end else begin
      case (seq_q)
        SQ_IDLE: if (act && (d_rd || d_ld)) begin
          o_type_q   <= n_type;
          o_dst_q    <= n_dst;
          o_addr_q   <= cur_addr;
          o_data_q   <= in_data;
          inv_left_q <= n_inv;
          if (d_rd) begin
            seq_q <= SQ_READ;
          end else begin
            o_valid_q <= 1'b1;
            seq_q     <= SQ_SEND;
          end
        end
        SQ_READ: begin
          o_data_q  <= mem_rdata;
          o_valid_q <= 1'b1;
          seq_q     <= SQ_SEND;
        end
        SQ_SEND: if (out_ready) begin
          if (inv_left_q != '0) begin
            o_dst_q    <= oh_index(next_inv);
            inv_left_q <= inv_left_q & ~next_inv;
          end else begin
            o_valid_q <= 1'b0;
            seq_q     <= SQ_IDLE;
          end
        end
        default: seq_q <= SQ_IDLE;
      endcase
    end
  end

  assign out_valid = o_valid_q;
  assign out_type  = o_type_q;
  assign out_src   = SW'(HOME_ID);
  assign out_dst   = o_dst_q;
  assign out_addr  = o_addr_q;
  assign out_data  = o_data_q;

  // ---------------- submodules ----------------
  hdc_dir #(.NSITE(NSITE), .ADDR_W(ADDR_W), .SW(SW), .NBLK(NBLK)) u_dir (
    .clk(clk), .rst_n(rst_n),
    .ra_a(cur_addr), .ra_st(ra_st), .ra_vec(ra_vec), .ra_own(ra_own), .ra_req(ra_req),
    .rb_a(o_addr_q), .rb_st(rb_st), .rb_vec(rb_vec), .rb_own(rb_own),
    .we(dir_we), .wa(cur_addr), .w_st(w_st), .w_vec(w_vec), .w_own(w_own), .w_req(w_req),
    .busy(blk_busy)
  );

  hdc_park #(.DEPTH(PARK_DEPTH), .ADDR_W(ADDR_W), .SW(SW), .NBLK(NBLK)) u_park (
    .clk(clk), .rst_n(rst_n),
    .push(park_push), .push_ex(in_type == MI_EX_REQ), .push_src(in_src), .push_addr(in_addr),
    .pop(use_park), .busy(blk_busy),
    .pick_valid(pk_valid), .pick_ex(pk_ex), .pick_src(pk_src), .pick_addr(pk_addr),
    .full(pk_full)
  );

  // ---------------- assertions ----------------
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_type) && $stable(out_dst) && $stable(out_data)) else $error("output changed under stall"); // R2
  AST_INV_TO_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_type == MO_INV_CMD |-> rb_st == DS_WAIT_INV && rb_vec[out_dst]) else $error("invalidate to non-pending site"); // R4
  AST_EXGNT_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_type == MO_EX_GNT |-> rb_st == DS_OWNED && rb_own == out_dst) else $error("exclusive grant to non-owner"); // R3
  AST_GRANT_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_type == MO_SH_GNT |-> rb_st == DS_SHARED && rb_vec[out_dst]) else $error("shared grant on unsettled entry"); // R7
  AST_WRITE_FROM_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ra_st == DS_WAIT_DATA && ra_own == cur_src) else $error("memory write without recall"); // R5
  AST_REPLAY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    use_park |-> !in_ready) else $error("input taken over held request"); // R7
endmodule

// File: tb/home_dir_ctrl_tb_top.sv
module home_dir_ctrl_tb_top;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int SW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic          in_valid = 1'b0, in_ready;
  logic [2:0]    in_type = '0;
  logic [SW-1:0] in_src = '0;
  logic [AW-1:0] in_addr = '0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid, out_ready = 1'b1;
  logic [2:0]    out_type;
  logic [SW-1:0] out_src, out_dst;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] out_data;
  logic          mem_rd_en, mem_wr_en;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  home_dir_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_type(in_type), .in_src(in_src),
    .in_addr(in_addr), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type), .out_src(out_src),
    .out_dst(out_dst), .out_addr(out_addr), .out_data(out_data),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // backing memory model, one-cycle read
  logic [DW-1:0] mem [16];
  initial for (int a = 0; a < 16; a++) mem[a] = 16'hA000 + DW'(a);
  always @(posedge clk) begin
    if (mem_wr_en) mem[mem_addr] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
  end

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // scoreboard
  typedef struct {
    logic [2:0]    t;
    logic [SW-1:0] dst;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    bit            has_data;
    string         tag;
  } exp_t;
  exp_t exp_q[$];

  task automatic expect_msg(input logic [2:0] t, input int dst, input int addr,
                            input logic [DW-1:0] data, input string tag);
    exp_t e;
    e.t = t; e.dst = SW'(dst); e.addr = AW'(addr); e.data = data;
    e.has_data = (t == 3'd0) || (t == 3'd1);
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  bit stall_en = 1'b0;
  int stall_cnt = 0;
  always @(negedge clk) begin
    stall_cnt++;
    out_ready = !stall_en || (stall_cnt % 3 != 0);
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7", "unexpected output",
              {out_type, 6'(out_dst), 7'(out_addr), out_data}, 32'h0);
      end else begin
        exp_t e;
        bit ok;
        e = exp_q.pop_front();
        ok = (out_type == e.t) && (out_dst == e.dst) && (out_addr == e.addr) &&
             (out_src == SW'(0)) && (!e.has_data || out_data == e.data);
        check(ok, e.tag, "output message {type,dst,addr,data}",
              {out_type, 6'(out_dst), 7'(out_addr), out_data},
              {e.t, 6'(e.dst), 7'(e.addr), e.has_data ? e.data : out_data});
      end
    end
  end

  task automatic send(input logic [2:0] t, input int src, input int addr, input logic [DW-1:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_type = t; in_src = SW'(src); in_addr = AW'(addr); in_data = d;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while (exp_q.size() != 0 && n < 300) begin
      @(negedge clk);
      n++;
    end
    check(exp_q.size() == 0, tag, "expected outputs missing", exp_q.size(), 0);
    repeat (6) @(negedge clk);
  endtask

  // codes: in 0 sh req,1 ex req,2 wb rsp,3 inv ack,4 flush rsp ; out 0 sh gnt,1 ex gnt,2 wb,3 inv,4 flush
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // R2: shared read of a clean block
    expect_msg(3'd0, 1, 2, 16'hA002, "R2");
    send(3'd0, 1, 2, 0);
    drain("R2");

    // R3: sole sharer upgrades, then uncached block taken exclusive
    expect_msg(3'd1, 1, 2, 16'hA002, "R3");
    send(3'd1, 1, 2, 0);
    expect_msg(3'd1, 2, 5, 16'hA005, "R3");
    send(3'd1, 2, 5, 0);
    drain("R3");

    // R5: shared read of a modified block recalls from owner
    expect_msg(3'd2, 1, 2, 0, "R5");
    send(3'd0, 3, 2, 0);
    drain("R5");
    expect_msg(3'd0, 3, 2, 16'h1234, "R5");
    send(3'd2, 1, 2, 16'h1234);
    drain("R5");
    check(mem[2] == 16'h1234, "R5", "memory after write-back", mem[2], 16'h1234);

    // R4: exclusive request with two sharers, output stalls active
    stall_en = 1'b1;
    expect_msg(3'd3, 1, 2, 0, "R4");
    expect_msg(3'd3, 3, 2, 0, "R4");
    send(3'd1, 0, 2, 0);
    drain("R4");
    send(3'd3, 3, 2, 0);
    drain("R4");
    expect_msg(3'd1, 0, 2, 16'h1234, "R4");
    send(3'd3, 1, 2, 0);
    drain("R4");
    stall_en = 1'b0;

    // R6: exclusive request to modified block
    expect_msg(3'd4, 0, 2, 0, "R6");
    send(3'd1, 2, 2, 0);
    drain("R6");
    expect_msg(3'd1, 2, 2, 16'h5678, "R6");
    send(3'd4, 0, 2, 16'h5678);
    drain("R6");
    check(mem[2] == 16'h5678, "R6", "memory after flush", mem[2], 16'h5678);
    expect_msg(3'd2, 2, 2, 0, "R6");
    send(3'd0, 1, 2, 0);
    drain("R6");
    expect_msg(3'd0, 1, 2, 16'h9ABC, "R5");
    send(3'd2, 2, 2, 16'h9ABC);
    drain("R5");

    // R7 / R8: hold while invalidating, other block proceeds, replay beats fresh input
    stall_en = 1'b1;
    expect_msg(3'd3, 1, 2, 0, "R4");
    expect_msg(3'd3, 2, 2, 0, "R4");
    send(3'd1, 3, 2, 0);
    drain("R4");
    send(3'd0, 0, 2, 0);               // held: block 2 waits for acks
    expect_msg(3'd0, 0, 7, 16'hA007, "R8");
    send(3'd0, 0, 7, 0);
    drain("R8");
    send(3'd3, 1, 2, 0);
    drain("R7");
    expect_msg(3'd1, 3, 2, 16'h9ABC, "R4");
    expect_msg(3'd2, 3, 2, 0, "R7");   // replayed shared request recalls from new owner
    expect_msg(3'd0, 1, 7, 16'hA007, "R7");
    send(3'd3, 2, 2, 0);
    send(3'd0, 1, 7, 0);
    drain("R7");
    expect_msg(3'd0, 0, 2, 16'h0F0F, "R7");
    send(3'd2, 3, 2, 16'h0F0F);
    drain("R7");
    check(mem[2] == 16'h0F0F, "R7", "memory after replay recall", mem[2], 16'h0F0F);
    stall_en = 1'b0;

    // R9: stray acknowledgement to an owned block is dropped
    send(3'd3, 2, 5, 0);
    send(3'd2, 1, 5, 16'hDEAD);        // write-back from a non-owner, nothing pending
    drain("R9");
    check(mem[5] == 16'hA005, "R9", "memory untouched by stray reply", mem[5], 16'hA005);
    expect_msg(3'd4, 2, 5, 0, "R9");
    send(3'd1, 0, 5, 0);
    drain("R9");
    expect_msg(3'd1, 0, 5, 16'h2222, "R9");
    send(3'd4, 2, 5, 16'h2222);
    drain("R9");
    check(mem[5] == 16'h2222, "R9", "memory after flush", mem[5], 16'h2222);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule